// File: doc/BRIEF.md
# Hub Pointer Address Generator

This block turns the 9-bit source operand of a hub memory read or write into an effective hub address. It keeps two address pointers, A and B. When the operand's top bit is clear, its low byte is a plain address. When the top bit is set, the operand selects one of the pointers and adds a signed 5-bit offset to it. The offset is first scaled by the access size. The operand can also ask for the selected pointer to be written back with the offset result, either before the access (pre-update) or after it (post-update).

The same decoding serves every access size and both directions. The address is combinational: it is valid in the same cycle as the request strobe. A pointer write-back takes effect on the next rising clock edge. A separate load port lets the surrounding core write either pointer directly.

There is no back-pressure. The block accepts every strobe, so the interface needs no ready signal. The pointer outputs always show the current register contents.

Top module: `hub_ptr_agen`

## Requirements
- R1: When `req_src[8]` is 0, `eff_addr` equals `req_src[7:0]` zero-extended, `is_ptr_mode` is 0, and neither pointer changes.
- R2: When `req_src[8]` is 1, the operand is decoded as follows. Bit 7 selects the pointer (0 is A, 1 is B). Bit 6 set means the pointer is written back. Bit 5 picks post-update (1) or pre-update (0). Bits 4:0 hold the offset. `is_ptr_mode` is 1 while `req_valid` is high.
- R3: The offset is scaled by the access size. `req_size` 00 (byte) scales by 1, 01 (word) by 2, 10 (long) by 4 and 11 (quad) by 16.
- R4: The offset field is two's complement, covering -16 to +15. A negative scaled offset lowers the address.
- R5: With bit 6 clear, `eff_addr` is the pointer plus the scaled offset, and both pointers keep their values.
- R6: In pre-update mode, `eff_addr` is the pointer plus the scaled offset, and the selected pointer holds that same value after the next edge.
- R7: In post-update mode, `eff_addr` is the pointer's old value, and the pointer becomes old value plus scaled offset after the next edge.
- R8: Only the selected pointer changes, and only in a cycle where `req_valid` is high.
- R9: When `ld_en` is high, the pointer chosen by `ld_sel` (0 is A, 1 is B) takes `ld_value` on the next edge. This overrides a write-back to the same pointer in that cycle. A write-back to the other pointer still happens.
- R10: After reset, both pointers are zero.
- R11: Pointer arithmetic and the address wrap modulo 2^17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe; write-back only when high |
| req_src | input | 9 | Source operand |
| req_size | input | 2 | Access size code |
| ld_en | input | 1 | Pointer load enable |
| ld_sel | input | 1 | Pointer chosen for load |
| ld_value | input | 17 | Load value |
| eff_addr | output | 17 | Effective hub address |
| is_ptr_mode | output | 1 | Request uses a pointer |
| ptr_a | output | 17 | Pointer A contents |
| ptr_b | output | 17 | Pointer B contents |

## Verification
The bench builds the block with its default parameters: a 17-bit address, a 5-bit offset and two pointers. With these values, every offset code from -16 to +15 at every access size can be reached in a single operand. The load port can preload a pointer near 0 or near 2^17 - 1, so a quad-scaled offset crosses the wrap boundary in one step. Random operands and collisions between loads and write-backs are mixed with directed cases that cover each mode on both pointers.

// File: rtl/hub_agen_pkg.sv
package hub_agen_pkg;
  localparam int OFS_W = 5;
  localparam int IMM_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_QUAD = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic             is_ptr;
    logic             use_b;
    logic             wr_back;
    logic             post;
    logic [OFS_W-1:0] ofs;
    logic [IMM_W-1:0] imm;
  } src_dec_t;

  function automatic logic [2:0] size_shift(acc_size_e sz);
    case (sz)
      SZ_BYTE: return 3'd0;
      SZ_WORD: return 3'd1;
      SZ_LONG: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/hub_agen_decode.sv
module hub_agen_decode
  import hub_agen_pkg::*;
(
  input  logic [8:0] src,
  output src_dec_t   dec
);
  always_comb begin
    dec.is_ptr  = src[8];
    dec.use_b   = src[7];
    dec.wr_back = src[6];
    dec.post    = src[5];
    dec.ofs     = src[OFS_W-1:0];
    dec.imm     = src[IMM_W-1:0];
  end
endmodule

// File: rtl/hub_agen_scale.sv
module hub_agen_scale
  import hub_agen_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [OFS_W-1:0]  ofs,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] delta
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_sx;
  logic [2:0]        shamt;

  always_comb begin
    ofs_sx = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    shamt  = size_shift(size);
    delta  = ofs_sx << shamt;
  end
endmodule

// File: rtl/hub_agen_ptrs.sv
module hub_agen_ptrs #(
  parameter int ADDR_W = 17,
  parameter int NPTR   = 2,
  localparam int SEL_W = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd_en,
  input  logic [SEL_W-1:0]            upd_sel,
  input  logic [ADDR_W-1:0]           upd_val,
  input  logic                        ld_en,
  input  logic [SEL_W-1:0]            ld_sel,
  input  logic [ADDR_W-1:0]           ld_val,
  output logic [NPTR-1:0][ADDR_W-1:0] ptr
);
  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic hit_ld, hit_upd;
    assign hit_ld  = ld_en  && (ld_sel  == SEL_W'(i));
    assign hit_upd = upd_en && (upd_sel == SEL_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr[i] <= '0;
      else if (hit_ld)  ptr[i] <= ld_val;
      else if (hit_upd) ptr[i] <= upd_val;
    end
  end
endmodule

// File: rtl/hub_ptr_agen.sv
module hub_ptr_agen
  import hub_agen_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [8:0]        req_src,
  input  logic [1:0]        req_size,
  input  logic              ld_en,
  input  logic              ld_sel,
  input  logic [ADDR_W-1:0] ld_value,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              is_ptr_mode,
  output logic [ADDR_W-1:0] ptr_a,
  output logic [ADDR_W-1:0] ptr_b
);
  localparam int NPTR = 2;

  src_dec_t                   dec;
  logic [ADDR_W-1:0]          delta;
  logic [ADDR_W-1:0]          base;
  logic [ADDR_W-1:0]          sum;
  logic [NPTR-1:0][ADDR_W-1:0] ptr;
  logic                       upd_en;

  hub_agen_decode u_dec (
    .src (req_src),
    .dec (dec)
  );

  hub_agen_scale #(.ADDR_W(ADDR_W)) u_scale (
    .ofs   (dec.ofs),
    .size  (acc_size_e'(req_size)),
    .delta (delta)
  );

  always_comb begin
    base   = ptr[dec.use_b];
    sum    = base + delta;
    upd_en = req_valid && dec.is_ptr && dec.wr_back;
    if (!dec.is_ptr)
      eff_addr = {{(ADDR_W-IMM_W){1'b0}}, dec.imm};
    else if (dec.wr_back && dec.post)
      eff_addr = base;
    else
      eff_addr = sum;
  end

  hub_agen_ptrs #(.ADDR_W(ADDR_W), .NPTR(NPTR)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .upd_sel (dec.use_b),
    .upd_val (sum),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_val  (ld_value),
    .ptr     (ptr)
  );

  assign is_ptr_mode = req_valid && dec.is_ptr;
  assign ptr_a       = ptr[0];
  assign ptr_b       = ptr[1];
endmodule

// File: rtl/hub_ptr_agen_chk.sv
module hub_ptr_agen_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [8:0]        req_src,
  input logic              ld_en,
  input logic              ld_sel,
  input logic [ADDR_W-1:0] ld_value,
  input logic [ADDR_W-1:0] eff_addr,
  input logic              is_ptr_mode,
  input logic [ADDR_W-1:0] ptr_a,
  input logic [ADDR_W-1:0] ptr_b
);
  logic [ADDR_W-1:0] cur_sel;
  assign cur_sel = req_src[7] ? ptr_b : ptr_a;

  a_r1_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_src[8]) |->
      (eff_addr == ADDR_W'(req_src[7:0]) && !is_ptr_mode));

  a_r1_imm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_src[8] && !ld_en) |=> ($stable(ptr_a) && $stable(ptr_b)));

  a_r5_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src[8] && !req_src[6] && !ld_en) |=>
      ($stable(ptr_a) && $stable(ptr_b)));

  a_r6_pre_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src[8] && req_src[6] && !req_src[5] && !ld_en) |=>
      ((req_src[7] ? ptr_b : ptr_a) == $past(eff_addr) || $past(req_src[7]) != req_src[7]));

  a_r7_post_old: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src[8] && req_src[6] && req_src[5]) |-> (eff_addr == cur_sel));

  a_r8_other_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src[8] && req_src[7] && !(ld_en && !ld_sel)) |=> $stable(ptr_a));

  a_r8_other_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src[8] && !req_src[7] && !(ld_en && ld_sel)) |=> $stable(ptr_b));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !ld_en) |=> ($stable(ptr_a) && $stable(ptr_b)));

  a_r9_load_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !ld_sel) |=> (ptr_a == $past(ld_value)));

  a_r9_load_b: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_sel) |=> (ptr_b == $past(ld_value)));
endmodule

bind hub_ptr_agen hub_ptr_agen_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_src     (req_src),
  .ld_en       (ld_en),
  .ld_sel      (ld_sel),
  .ld_value    (ld_value),
  .eff_addr    (eff_addr),
  .is_ptr_mode (is_ptr_mode),
  .ptr_a       (ptr_a),
  .ptr_b       (ptr_b)
);

// File: tb/hub_ptr_agen_tb_top.sv
`timescale 1ns/1ps
module hub_ptr_agen_tb_top;
  localparam int AW   = 17;
  localparam int MASK = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [8:0]    req_src = '0;
  logic [1:0]    req_size = '0;
  logic          ld_en = 1'b0;
  logic          ld_sel = 1'b0;
  logic [AW-1:0] ld_value = '0;
  logic [AW-1:0] eff_addr;
  logic          is_ptr_mode;
  logic [AW-1:0] ptr_a;
  logic [AW-1:0] ptr_b;

  int checks = 0;
  int errors = 0;
  int ref_p[2];

  always #2.5 clk = ~clk;

  hub_ptr_agen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
    .req_size(req_size), .ld_en(ld_en), .ld_sel(ld_sel), .ld_value(ld_value),
    .eff_addr(eff_addr), .is_ptr_mode(is_ptr_mode), .ptr_a(ptr_a), .ptr_b(ptr_b)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int scaled_ofs(logic [8:0] src, logic [1:0] sz);
    int o = int'(src[4:0]);
    if (o >= 16) o -= 32;
    return o * ((sz == 2'b11) ? 16 : (1 << sz));
  endfunction

  // One cycle: drive, check combinational outputs and pointers, then advance the model.
  task automatic step(string tag, logic v, logic [8:0] src, logic [1:0] sz,
                      logic le, logic ls, int lv);
    int p, sum, exp_ea;
    logic modf;
    @(negedge clk);
    req_valid = v; req_src = src; req_size = sz;
    ld_en = le; ld_sel = ls; ld_value = AW'(lv);
    #1;
    p   = ref_p[src[7]];
    sum = (p + scaled_ofs(src, sz)) & MASK;
    if (!src[8])               exp_ea = int'(src[7:0]);
    else if (src[6] && src[5]) exp_ea = p;
    else                       exp_ea = sum;
    check("R10/R8", "ptr_a", int'(ptr_a), ref_p[0]);
    check("R10/R8", "ptr_b", int'(ptr_b), ref_p[1]);
    if (v) begin
      check(tag, "eff_addr", int'(eff_addr), exp_ea);
      check("R2", "is_ptr_mode", int'(is_ptr_mode), int'(src[8]));
    end
    modf = v && src[8] && src[6];
    @(posedge clk);
    if (modf && !(le && ls == src[7])) ref_p[src[7]] = sum;
    if (le) ref_p[ls] = lv & MASK;
  endtask

  function automatic logic [8:0] op(bit b, bit m, bit post, int ofs);
    return {1'b1, b, m, post, 5'(ofs)};
  endfunction

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ref_p[0] = 0; ref_p[1] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10 reset state
    step("R10", 0, 9'h000, 2'b00, 0, 0, 0);
    // R1 immediate addresses
    step("R1", 1, 9'h0FF, 2'b10, 0, 0, 0);
    step("R1", 1, 9'h05A, 2'b11, 0, 0, 0);
    // R9 loads
    step("R9", 0, 9'h000, 2'b00, 1, 0, 1000);
    step("R9", 0, 9'h000, 2'b00, 1, 1, 5000);
    // R5 offset only, R3 each size, R4 negative
    for (int s = 0; s < 4; s++) step("R5/R3", 1, op(0, 0, 0, 3), 2'(s), 0, 0, 0);
    step("R4", 1, op(1, 0, 0, -16), 2'b11, 0, 0, 0);
    step("R4", 1, op(0, 0, 0, 15), 2'b01, 0, 0, 0);
    // R6 pre-increment long by 2 (+8)
    step("R6", 1, op(0, 1, 0, 2), 2'b10, 0, 0, 0);
    step("R6", 1, op(1, 1, 0, -1), 2'b00, 0, 0, 0);
    // R7 post-decrement long by 6 (-24)
    step("R7", 1, op(0, 1, 1, -6), 2'b10, 0, 0, 0);
    step("R7", 1, op(1, 1, 1, 7), 2'b11, 0, 0, 0);
    // R8 no strobe: write-back operand ignored
    step("R8", 0, op(0, 1, 0, 5), 2'b10, 0, 0, 0);
    step("R8", 1, op(0, 0, 0, 0), 2'b00, 0, 0, 0);
    // R9 load wins over write-back to same pointer; other pointer still updates
    step("R9", 1, op(0, 1, 0, 4), 2'b10, 1, 0, 77);
    step("R9", 1, op(1, 1, 1, 4), 2'b10, 1, 0, 99);
    // R11 wrap both directions
    step("R11", 0, 9'h000, 2'b00, 1, 0, MASK - 3);
    step("R11", 1, op(0, 1, 0, 1), 2'b11, 0, 0, 0);
    step("R11", 1, op(0, 1, 1, -1), 2'b11, 0, 0, 0);
    step("R11", 1, op(0, 0, 0, 0), 2'b00, 0, 0, 0);
    // mixed random traffic
    for (int i = 0; i < 400; i++)
      step("R2", 1'($urandom_range(0, 3) != 0), 9'($urandom), 2'($urandom),
           1'($urandom_range(0, 7) == 0), 1'($urandom), int'($urandom & MASK));
    step("R8", 0, 9'h000, 2'b00, 0, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule